// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM with Late Write

This block is a synthesizable model of a synchronous static RAM. It delays write data so that its pipeline is exactly as deep as the read pipeline. Reads and writes can therefore follow each other on consecutive clock edges with no idle cycle on the data bus. Address, the three chip selects, write enable, active-low byte selects, the load/continue control and the active-low clock enable are all sampled on the rising clock edge. A built-in two-bit burst counter produces the addresses for continue cycles.

Two static inputs pick the timing and the burst order. The timing is either pipelined, with a registered output, or flow-through, with a combinational output from the array. The burst order is either linear or interleaved. An active-low output enable gates the drivers asynchronously. A sleep input freezes the whole device two edges after it is raised. The bidirectional data bus appears as three separate vectors: write data in, read data out, and a per-lane drive enable. All three are built from 9-bit byte lanes. The memory depth is set by the address width parameter.

Top module: `lockstep_sram`

## Requirements
- R1: An edge at which `clken_n` is high changes no state. In pipelined mode a read output that is being driven stays driven with the same data through the stall. A write that is in flight leaves the bus undriven, and its data is taken at a later active edge.
- R2: A load cycle (`burst_cont`=0) selects the device only when `cs0_n`=0, `cs1`=1 and `cs2_n`=0. Any other combination is a deselect: nothing is written and nothing is driven.
- R3: With `burst_cont`=1 the cycle repeats the type of the last operation (read, write or deselect) at the next burst address. Chip selects, `we_n` and `addr` are ignored in such a cycle. For a write continue, `bytesel_n` is sampled again.
- R4: With `flow_mode`=0, a read command sampled at active edge k is driven from active edge k+1 on. Write data for a write command sampled at active edge k is taken from `wdata` at active edge k+2.
- R5: With `flow_mode`=1, a read command sampled at active edge k is driven right after edge k. Write data is taken from `wdata` at active edge k+1.
- R6: `bytesel_n[i]`=0 writes lane i, which is bits [9i+8:9i]. A write with every `bytesel_n` bit high is an abort and changes no memory word.
- R7: A continue cycle steps a two-bit count that starts at 0 and wraps after four addresses. The upper address bits stay unchanged. The low two bits are start+count mod 4 when `interleave`=0, and start XOR count when `interleave`=1.
- R8: `rdrive` is high only for read data. It is low during writes, write aborts and deselects, and whenever `oe_n` is high. `oe_n` acts without waiting for a clock edge. `rdata` is zero whenever `rdrive` is low. A read issued while `oe_n` is high is a dummy read.
- R10: A continue cycle that follows a deselect is itself a deselect.
- R11: When `sleep` is sampled high at edge k, the device is asleep from edge k+2 on. It wakes two edges after `sleep` is sampled low. While asleep, `rdrive` is low, every other input is ignored, and all state is preserved.
- R12: After reset both pipelines are empty and `rdrive` is low.
- R13: A read always returns the most recently written data for its address. This includes the case where the write is committed at the same edge at which the read data is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline state |
| clken_n | input | 1 | Active-low clock enable; high stalls the edge |
| cs0_n | input | 1 | Chip select, active low |
| cs1 | input | 1 | Chip select, active high |
| cs2_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write enable, active low |
| burst_cont | input | 1 | 0 = load new address and type, 1 = continue burst |
| bytesel_n | input | LANES | Active-low write enable per 9-bit lane |
| addr | input | ADDR_W | Word address |
| wdata | input | 9*LANES | Write data, sampled at the late-write edge |
| oe_n | input | 1 | Asynchronous active-low output enable |
| sleep | input | 1 | Sleep request, effective two edges later |
| flow_mode | input | 1 | Static: 0 pipelined, 1 flow-through |
| interleave | input | 1 | Static: 0 linear, 1 interleaved burst order |
| rdata | output | 9*LANES | Read data, zero when not driven |
| rdrive | output | LANES | Per-lane output driver enable |

## Verification
A command stage that holds a stale operation type, or a burst count that steps wrongly, shows up at the next read data word. On a continue, the bad type or address appears on `rdata` one edge later in flow-through mode and two edges later in pipelined mode. A write committed from the wrong stage, or with the wrong lane mask, stays hidden until that word is read back. A write and read at the same address on adjacent edges expose the problem within four edges. A broken stall or sleep freeze is seen at once as a dropped or premature `rdrive`, or as data that shifts by one word.

// File: rtl/lss_pkg.sv
package lss_pkg;

    localparam int BYTE_W = 9;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

endpackage

// File: rtl/lss_burst.sv
module lss_burst #(
    parameter int ADDR_W = 6
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [1:0]        step,
    input  logic              interleave,
    output logic [ADDR_W-1:0] addr
);

    logic [1:0] low;

    // Linear order adds the step, interleaved order flips bits by it.
    assign low = interleave ? (base[1:0] ^ step) : (base[1:0] + step);

    generate
        if (ADDR_W > 2) begin : g_upper
            assign addr = {base[ADDR_W-1:2], low};
        end else begin : g_low_only
            assign addr = low;
        end
    endgenerate

endmodule

// File: rtl/lss_array.sv
module lss_array
    import lss_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4
) (
    input  logic                      clk,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [LANES-1:0]          wr_mask,
    input  logic [LANES*BYTE_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0]         rd_addr,
    output logic [LANES*BYTE_W-1:0]   rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    // One storage column per byte lane, each with its own write strobe.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [BYTE_W-1:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && wr_mask[l]) begin
                cells[wr_addr] <= wr_data[l*BYTE_W +: BYTE_W];
            end
        end

        assign rd_data[l*BYTE_W +: BYTE_W] = cells[rd_addr];
    end

endmodule

// File: rtl/lss_ctrl.sv
module lss_ctrl
    import lss_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clken_n,
    input  logic                      cs0_n,
    input  logic                      cs1,
    input  logic                      cs2_n,
    input  logic                      we_n,
    input  logic                      burst_cont,
    input  logic [LANES-1:0]          bytesel_n,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [LANES*BYTE_W-1:0]   wdata,
    input  logic                      oe_n,
    input  logic                      sleep,
    input  logic                      flow_mode,
    input  logic                      interleave,
    input  logic [LANES*BYTE_W-1:0]   rd_data,
    output logic [ADDR_W-1:0]         rd_addr,
    output logic                      wr_en,
    output logic [ADDR_W-1:0]         wr_addr,
    output logic [LANES-1:0]          wr_mask,
    output logic [LANES*BYTE_W-1:0]   dout,
    output logic [LANES-1:0]          drive
);

    localparam int DW = LANES * BYTE_W;

    typedef struct packed {
        op_e               last_op;
        logic [ADDR_W-1:0] base;
        logic [1:0]        cnt;
        op_e               s1_op;
        logic [ADDR_W-1:0] s1_addr;
        logic [LANES-1:0]  s1_mask;
        op_e               s2_op;
        logic [ADDR_W-1:0] s2_addr;
        logic [LANES-1:0]  s2_mask;
        logic              pv;
        logic [DW-1:0]     pd;
        logic              sl1;
        logic              sl2;
    } st_t;

    st_t st_q, st_d;

    logic              act;
    logic              sel;
    logic [1:0]        cnt_nx;
    logic [ADDR_W-1:0] cont_addr;
    op_e               c_op;
    logic [ADDR_W-1:0] c_addr;
    logic [LANES-1:0]  c_mask;
    logic [DW-1:0]     merged;
    logic              drv_int;
    logic [DW-1:0]     dat_int;
    logic              out_en;

    assign cnt_nx = st_q.cnt + 2'd1;

    lss_burst #(.ADDR_W(ADDR_W)) u_burst (
        .base       (st_q.base),
        .step       (cnt_nx),
        .interleave (interleave),
        .addr       (cont_addr)
    );

    always_comb begin
        st_d   = st_q;
        act    = !clken_n && !st_q.sl2;
        sel    = !cs0_n && cs1 && !cs2_n;

        // Commit point: one stage deep in flow-through, two when pipelined.
        c_op   = flow_mode ? st_q.s1_op   : st_q.s2_op;
        c_addr = flow_mode ? st_q.s1_addr : st_q.s2_addr;
        c_mask = flow_mode ? st_q.s1_mask : st_q.s2_mask;
        wr_en  = act && (c_op == OP_WRITE) && (|c_mask);

        // Forward lanes committed at this edge into the output register.
        for (int l = 0; l < LANES; l++) begin
            merged[l*BYTE_W +: BYTE_W] =
                (wr_en && c_mask[l] && (c_addr == st_q.s1_addr)) ?
                wdata[l*BYTE_W +: BYTE_W] : rd_data[l*BYTE_W +: BYTE_W];
        end

        // Sleep request ripples through two flops on every edge.
        st_d.sl1 = sleep;
        st_d.sl2 = st_q.sl1;

        if (act) begin
            st_d.pv      = (st_q.s1_op == OP_READ);
            st_d.pd      = merged;
            st_d.s2_op   = st_q.s1_op;
            st_d.s2_addr = st_q.s1_addr;
            st_d.s2_mask = st_q.s1_mask;
            if (!burst_cont) begin
                st_d.base    = addr;
                st_d.cnt     = 2'd0;
                st_d.s1_addr = addr;
                if (!sel) begin
                    st_d.s1_op = OP_IDLE;
                end else begin
                    st_d.s1_op = we_n ? OP_READ : OP_WRITE;
                end
            end else begin
                st_d.cnt     = cnt_nx;
                st_d.s1_addr = cont_addr;
                st_d.s1_op   = st_q.last_op;
            end
            st_d.s1_mask = (st_d.s1_op == OP_WRITE) ? ~bytesel_n : '0;
            st_d.last_op = st_d.s1_op;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_addr = st_q.s1_addr;
    assign wr_addr = c_addr;
    assign wr_mask = c_mask;

    assign drv_int = flow_mode ? (st_q.s1_op == OP_READ) : st_q.pv;
    assign dat_int = flow_mode ? rd_data : st_q.pd;
    assign out_en  = drv_int && !oe_n && !st_q.sl2;
    assign drive   = {LANES{out_en}};
    assign dout    = out_en ? dat_int : '0;

    // R1: a stalled edge leaves the command stage and output register alone
    a_r1_stall_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        clken_n |=> ($stable(st_q.s1_op) && $stable(st_q.s1_addr) &&
                     $stable(st_q.pv) && $stable(st_q.pd)));

    // R4: a read in the command stage reaches the output register next active edge
    a_r4_pipe_read_out: assert property (@(posedge clk) disable iff (!rst_n)
        (!flow_mode && !clken_n && !st_q.sl2 && st_q.s1_op == OP_READ) |=> st_q.pv);

    // R7: every active continue steps the two-bit burst count by one, wrapping
    a_r7_burst_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!clken_n && !st_q.sl2 && burst_cont) |=> (st_q.cnt == $past(st_q.cnt) + 2'd1));

    // R10: continuing after a deselect keeps the device deselected
    a_r10_desel_continue: assert property (@(posedge clk) disable iff (!rst_n)
        (!clken_n && !st_q.sl2 && burst_cont && st_q.last_op == OP_IDLE)
        |=> (st_q.s1_op == OP_IDLE));

    // R11: sleep takes hold two edges after the request is sampled
    a_r11_sleep_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.sl2) |-> $past(sleep, 2));

endmodule

// File: rtl/lockstep_sram.sv
module lockstep_sram
    import lss_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clken_n,
    input  logic                      cs0_n,
    input  logic                      cs1,
    input  logic                      cs2_n,
    input  logic                      we_n,
    input  logic                      burst_cont,
    input  logic [LANES-1:0]          bytesel_n,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [LANES*BYTE_W-1:0]   wdata,
    input  logic                      oe_n,
    input  logic                      sleep,
    input  logic                      flow_mode,
    input  logic                      interleave,
    output logic [LANES*BYTE_W-1:0]   rdata,
    output logic [LANES-1:0]          rdrive
);

    localparam int DW = LANES * BYTE_W;

    logic [ADDR_W-1:0] rd_addr;
    logic [DW-1:0]     rd_data;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [LANES-1:0]  wr_mask;

    lss_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .clken_n    (clken_n),
        .cs0_n      (cs0_n),
        .cs1        (cs1),
        .cs2_n      (cs2_n),
        .we_n       (we_n),
        .burst_cont (burst_cont),
        .bytesel_n  (bytesel_n),
        .addr       (addr),
        .wdata      (wdata),
        .oe_n       (oe_n),
        .sleep      (sleep),
        .flow_mode  (flow_mode),
        .interleave (interleave),
        .rd_data    (rd_data),
        .rd_addr    (rd_addr),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_mask    (wr_mask),
        .dout       (rdata),
        .drive      (rdrive)
    );

    lss_array #(.ADDR_W(ADDR_W), .LANES(LANES)) u_array (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_mask (wr_mask),
        .wr_data (wdata),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    // R8: the data bus is never driven while a write is being committed
    a_r8_quiet_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (rdrive == '0));

endmodule

// File: tb/lockstep_sram_tb.sv
module lockstep_sram_tb;

    localparam int AW    = 6;
    localparam int LANES = 4;
    localparam int DW    = LANES * 9;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic             clken_n = 1'b0;
    logic             cs0_n = 1'b1, cs1 = 1'b0, cs2_n = 1'b1;
    logic             we_n = 1'b1, burst_cont = 1'b0;
    logic [LANES-1:0] bytesel_n = '1;
    logic [AW-1:0]    addr = '0;
    logic [DW-1:0]    wdata = '0;
    logic             oe_n = 1'b0, sleep = 1'b0;
    logic             flow_mode = 1'b0, interleave = 1'b0;
    logic [DW-1:0]    rdata;
    logic [LANES-1:0] rdrive;

    lockstep_sram #(.ADDR_W(AW), .LANES(LANES)) u_dut (
        .clk(clk), .rst_n(rst_n), .clken_n(clken_n),
        .cs0_n(cs0_n), .cs1(cs1), .cs2_n(cs2_n), .we_n(we_n),
        .burst_cont(burst_cont), .bytesel_n(bytesel_n), .addr(addr),
        .wdata(wdata), .oe_n(oe_n), .sleep(sleep), .flow_mode(flow_mode),
        .interleave(interleave), .rdata(rdata), .rdrive(rdrive)
    );

    int checks = 0;
    int errors = 0;

    // Reference contents and per-lane "has been written" flags.
    logic [DW-1:0]    ref_mem   [DEPTH];
    logic [LANES-1:0] ref_known [DEPTH];

    // Behavioural model state (0 idle, 1 read, 2 write).
    logic [1:0]       m_last, m1_op, m2_op;
    logic [AW-1:0]    m_base, m1_addr, m2_addr;
    logic [1:0]       m_cnt;
    logic [LANES-1:0] m1_mask, m2_mask, m_pk;
    logic             m_pv, m_sl1, m_sl2;
    logic [DW-1:0]    m_pd;

    function automatic logic [AW-1:0] exp_burst(input logic [AW-1:0] b,
                                                 input logic [1:0] c,
                                                 input logic ilv);
        logic [1:0] low;
        low = ilv ? (b[1:0] ^ c) : (b[1:0] + c);
        return {b[AW-1:2], low};
    endfunction

    task automatic model_reset();
        m_last = 2'd0; m1_op = 2'd0; m2_op = 2'd0;
        m_base = '0; m1_addr = '0; m2_addr = '0; m_cnt = 2'd0;
        m1_mask = '0; m2_mask = '0; m_pk = '0; m_pv = 1'b0; m_pd = '0;
        m_sl1 = 1'b0; m_sl2 = 1'b0;
    endtask

    task automatic model_edge();
        logic             act, sel;
        logic [1:0]       cop, nop;
        logic [AW-1:0]    ca, na;
        logic [LANES-1:0] cm;
        if (!rst_n) begin
            model_reset();
            return;
        end
        act = !clken_n && !m_sl2;
        if (act) begin
            cop = flow_mode ? m1_op   : m2_op;
            ca  = flow_mode ? m1_addr : m2_addr;
            cm  = flow_mode ? m1_mask : m2_mask;
            if (cop == 2'd2) begin
                for (int l = 0; l < LANES; l++) begin
                    if (cm[l]) begin
                        ref_mem[ca][l*9 +: 9] = wdata[l*9 +: 9];
                        ref_known[ca][l] = 1'b1;
                    end
                end
            end
            m_pv = (m1_op == 2'd1);
            m_pd = ref_mem[m1_addr];
            m_pk = ref_known[m1_addr];
            m2_op = m1_op; m2_addr = m1_addr; m2_mask = m1_mask;
            sel = !cs0_n && cs1 && !cs2_n;
            if (!burst_cont) begin
                m_base = addr; m_cnt = 2'd0; na = addr;
                nop = sel ? (we_n ? 2'd1 : 2'd2) : 2'd0;
            end else begin
                m_cnt = m_cnt + 2'd1;
                na = exp_burst(m_base, m_cnt, interleave);
                nop = m_last;
            end
            m1_op = nop; m1_addr = na;
            m1_mask = (nop == 2'd2) ? ~bytesel_n : '0;
            m_last = nop;
        end
        m_sl2 = m_sl1;
        m_sl1 = sleep;
    endtask

    task automatic check_out(input string tag);
        logic             den, ok;
        logic [DW-1:0]    dd;
        logic [LANES-1:0] dk;
        if (flow_mode) begin
            den = (m1_op == 2'd1); dd = ref_mem[m1_addr]; dk = ref_known[m1_addr];
        end else begin
            den = m_pv; dd = m_pd; dk = m_pk;
        end
        den = den && !oe_n && !m_sl2;
        ok = (rdrive == {LANES{den}});
        for (int l = 0; l < LANES; l++) begin
            if (den && dk[l] && rdata[l*9 +: 9] != dd[l*9 +: 9]) ok = 1'b0;
            if (!den && rdata[l*9 +: 9] != 9'd0) ok = 1'b0;
        end
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s t=%0t rdrive=%b rdata=%h expected rdrive=%b rdata=%h (known lanes %b)",
                     tag, $time, rdrive, rdata, {LANES{den}}, den ? dd : '0, dk);
        end
    endtask

    task automatic cyc(input string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check_out(tag);
    endtask

    task automatic desel();
        clken_n = 1'b0; cs0_n = 1'b1; cs1 = 1'b1; cs2_n = 1'b0;
        we_n = 1'b1; burst_cont = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a);
        clken_n = 1'b0; cs0_n = 1'b0; cs1 = 1'b1; cs2_n = 1'b0;
        we_n = 1'b1; burst_cont = 1'b0; addr = a;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [LANES-1:0] bn);
        clken_n = 1'b0; cs0_n = 1'b0; cs1 = 1'b1; cs2_n = 1'b0;
        we_n = 1'b0; burst_cont = 1'b0; addr = a; bytesel_n = bn;
    endtask

    task automatic cont(input logic [LANES-1:0] bn);
        clken_n = 1'b0; burst_cont = 1'b1; bytesel_n = bn;
    endtask

    task automatic do_reset(input string tag);
        @(negedge clk);
        rst_n = 1'b0;
        desel();
        cyc(tag);
        cyc(tag);
        rst_n = 1'b1;
        cyc(tag);
    endtask

    task automatic rand_cycle(input string tag);
        int r;
        clken_n    = ($urandom % 8 == 0);
        burst_cont = ($urandom % 4 == 0);
        r = int'($urandom % 10);
        cs0_n = (r == 7); cs1 = (r != 8); cs2_n = (r == 9);
        we_n       = $urandom % 2 == 0;
        bytesel_n  = ($urandom % 5 == 0) ? '1 : LANES'($urandom);
        addr       = AW'($urandom % 16);
        wdata      = DW'({$urandom, $urandom});
        oe_n       = ($urandom % 10 == 0);
        cyc(tag);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog R12 actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < DEPTH; i++) begin
            ref_mem[i] = '0;
            ref_known[i] = '0;
        end
        model_reset();

        // R12: reset state, pipelined linear
        do_reset("R12");

        // R4 / R13: write then read same word on the next edge
        wr(6'd5, '0); wdata = 36'h0_AAAA_5555; cyc("R4");
        rd(6'd5);     wdata = 36'h0_BBBB_0000; cyc("R13");
        desel();      wdata = 36'h1_2345_6789; cyc("R13");
        desel();      wdata = 36'h0_DEAD_0000; cyc("R4");
        desel(); cyc("R4");
        wr(6'd9, '0); cyc("R4");
        desel(); wdata = 36'h0_1111_2222; cyc("R4");
        desel(); wdata = 36'h0_3333_4444; cyc("R4");
        rd(6'd9); cyc("R4");
        desel(); cyc("R4");
        desel(); cyc("R4");

        // R6: abort, then partial lane write
        wr(6'd5, '1); cyc("R6");
        desel(); wdata = 36'hF_FFFF_FFFF; cyc("R6");
        desel(); cyc("R6");
        rd(6'd5); cyc("R6");
        desel(); cyc("R6");
        wr(6'd5, 4'b1010); cyc("R6");
        desel(); cyc("R6");
        desel(); wdata = 36'h5_A5A5_A5A5; cyc("R6");
        rd(6'd5); cyc("R6");
        desel(); cyc("R6");
        desel(); cyc("R6");

        // R7: linear burst write from 5 (5,6,7,4), read back with wrap
        wr(6'd5, '0); cyc("R7");
        cont('0); cyc("R7");
        cont('0); wdata = 36'h0_0000_0105; cyc("R7");
        cont('0); wdata = 36'h0_0000_0106; cyc("R7");
        desel(); wdata = 36'h0_0000_0107; cyc("R7");
        desel(); wdata = 36'h0_0000_0104; cyc("R7");
        rd(6'd5); cyc("R7");
        for (int i = 0; i < 4; i++) begin cont('1); cyc("R7"); end
        desel(); cyc("R7");
        desel(); cyc("R7");
        // R7: interleaved order from 5 is 5,4,7,6
        interleave = 1'b1;
        rd(6'd5); cyc("R7");
        for (int i = 0; i < 4; i++) begin cont('1); cyc("R7"); end
        desel(); cyc("R7");
        desel(); cyc("R7");
        interleave = 1'b0;

        // R1: stall while read output is driven, then during a write
        rd(6'd5); cyc("R1");
        desel(); cyc("R1");
        clken_n = 1'b1; addr = 6'd9; we_n = 1'b0; cyc("R1");
        clken_n = 1'b1; cyc("R1");
        desel(); cyc("R1");
        wr(6'd7, '0); cyc("R1");
        clken_n = 1'b1; wdata = 36'h0_BAD0_BAD0; cyc("R1");
        clken_n = 1'b1; cyc("R1");
        desel(); wdata = 36'h0_BAD1_BAD1; cyc("R1");
        desel(); wdata = 36'h0_7777_0007; cyc("R1");
        rd(6'd7); cyc("R1");
        desel(); cyc("R1");
        desel(); cyc("R1");

        // R3: continue ignores selects, write enable and address
        rd(6'd4); cyc("R3");
        cont('0); cs0_n = 1'b1; cs1 = 1'b0; we_n = 1'b0; addr = 6'd9; cyc("R3");
        desel(); cyc("R3");
        desel(); cyc("R3");

        // R2 / R10: deselected write and deselect-continue do nothing
        wr(6'd5, '0); cs1 = 1'b0; cyc("R2");
        cont('0); cs1 = 1'b1; cs0_n = 1'b0; we_n = 1'b0; cyc("R10");
        desel(); wdata = 36'hF_0F0F_0F0F; cyc("R10");
        desel(); cyc("R2");
        rd(6'd5); cyc("R2");
        rd(6'd6); cyc("R2");
        desel(); cyc("R2");
        desel(); cyc("R2");

        // R8: asynchronous output enable and dummy read
        rd(6'd5); cyc("R8");
        desel(); cyc("R8");
        oe_n = 1'b1; #1; check_out("R8");
        oe_n = 1'b0; #1; check_out("R8");
        oe_n = 1'b1; rd(6'd6); cyc("R8");
        desel(); cyc("R8");
        oe_n = 1'b0; #1; check_out("R8");
        desel(); cyc("R8");

        // R11: sleep entry after two edges, inputs ignored, clean wake
        rd(6'd5); cyc("R11");
        desel(); cyc("R11");
        sleep = 1'b1; cyc("R11");
        cyc("R11");
        wr(6'd5, '0); wdata = 36'h0_5EE5_5EE5; cyc("R11");
        cyc("R11");
        rd(6'd6); cyc("R11");
        sleep = 1'b0; desel(); cyc("R11");
        cyc("R11");
        cyc("R11");
        rd(6'd5); cyc("R11");
        desel(); cyc("R11");
        desel(); cyc("R11");

        // R5: flow-through timing
        flow_mode = 1'b1;
        do_reset("R12");
        wr(6'd8, '0); cyc("R5");
        desel(); wdata = 36'h0_8888_0008; cyc("R5");
        rd(6'd8); cyc("R5");
        wr(6'd8, 4'b1110); cyc("R5");
        rd(6'd8); wdata = 36'h0_0000_01EE; cyc("R5");
        clken_n = 1'b1; cyc("R1");
        desel(); cyc("R5");

        // Random traffic in all four timing/order combinations
        for (int m = 0; m < 4; m++) begin
            flow_mode  = m[0];
            interleave = m[1];
            do_reset("R12");
            for (int i = 0; i < 1500; i++) begin
                rand_cycle(flow_mode ? "R5" : "R4");
            end
            oe_n = 1'b0;
            desel(); cyc("R13");
            desel(); cyc("R13");
            desel(); cyc("R13");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule